// File: doc/BRIEF.md
# SD Card SPI-Mode Command Issuer

This block sends a single SD/MMC command to a card that is wired in SPI mode, and it returns the card's one-byte R1 status. The caller supplies a 6-bit command index and a 32-bit argument. On a start pulse the block builds a seven-byte frame and computes the CRC7 check byte in hardware. It shifts the frame out MSB first through its own SPI byte-exchange engine in mode 0. It then clocks out idle bytes and watches what comes back on MISO until a valid status byte appears or a fixed poll budget runs out.

The captured byte is sorted into outcome classes so that the caller does not have to decode the bits: card absent, command CRC fault, other fault, and card still idle. A second mode, chosen by `wake_mode` when `start` is asserted, runs the power-up preamble instead. This mode sends a run of all-ones bytes on a slower SCLK while chip select stays high. Response payloads longer than one byte and data blocks are handled elsewhere.

Top module: `sd_cmd_issuer`

## Requirements
- R1: A command frame is seven bytes, sent MSB first in SPI mode 0 (MOSI changes while SCLK is low and MISO is sampled on the rising edge). The bytes are: 0xFF, then `{2'b01, cmd_idx}`, then `cmd_arg` bits 31:24, 23:16, 15:8 and 7:0.
- R2: Frame byte 6 is `{crc7, 1'b1}`. Here crc7 uses the polynomial x^7 + x^3 + 1 with an initial value of zero. It runs MSB first over frame bytes 1 to 5. CMD0 with argument 0 gives 0x95, and CMD8 with argument 0x000001AA gives 0x87.
- R3: After the frame, the block reads up to POLL_MAX (8) bytes while sending 0xFF. The first byte read is always discarded. The first later byte whose bit 7 is 0 becomes `r1`, and no further bytes are clocked.
- R4: When no byte in the poll window qualifies, `timeout` is 1 and `r1` holds the last byte read. Otherwise `timeout` is 0.
- R5: The flags are decoded from `r1` as follows. `no_card` = (r1 == 0xFF). `crc_err` = r1[3] and not no_card. `gen_err` = any of r1[7:1] set, and neither no_card nor crc_err. `card_idle` = r1[0] and not no_card. At most one of no_card, crc_err and gen_err is high.
- R6: `cs_n` goes low in the cycle after a command start, before the first SCLK edge. It stays low through the last poll byte and is high again when `done` pulses.
- R7: In wake mode the block gives 8*INIT_BYTES (144) SCLK rising edges with MOSI high and `cs_n` held high throughout. Each SCLK half period lasts INIT_HALF clocks. On completion `r1` reads 0x00 and `timeout` reads 0.
- R8: `start` is taken only while `busy` is low. Index and argument are latched at that edge. `busy` stays high until a one-cycle `done` pulse. A `start` while busy is ignored, and `r1` and `timeout` change only as `done` rises.
- R9: After reset, `cs_n`=1, `sclk`=0, `mosi`=1, `busy`=0, `done`=0, `r1`=0x00 and `timeout`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| wake_mode | input | 1 | 1 = power-up preamble, 0 = command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| miso | input | 1 | Serial data from the card |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| r1 | output | 8 | Captured status byte |
| timeout | output | 1 | No valid status byte in the poll window |
| no_card | output | 1 | Status read as 0xFF |
| crc_err | output | 1 | Card reported a command CRC fault |
| gen_err | output | 1 | Any other fault bit set |
| card_idle | output | 1 | Card reports idle state |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data to the card |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that `start` is only a pulse request and that nothing else drives the SPI pins. They also assume that `miso` is stable while SCLK is high, as a card in mode 0 keeps it. The bench card model holds to this by changing MISO only right after a rising SCLK edge, for the bit that is sampled next. Each poll response is a prepared list of eight bytes, drawn as random, all-ones or MSB-clear bytes. Directed cases hit the discarded first byte, a match on the last byte, and a window with no match.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int FRAME_BYTES = 7;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAKE = 2'd1,
    SQ_SEND = 2'd2,
    SQ_POLL = 2'd3
  } seq_state_t;

  // CRC7, poly x^7+x^3+1, zero start, MSB first over 40 bits
  function automatic logic [6:0] crc7_calc(input logic [39:0] bits);
    logic [6:0] c;
    logic       fb;
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ bits[i];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  // Byte k of the outgoing command frame
  function automatic logic [7:0] frame_byte(input logic [2:0] k,
                                            input logic [5:0] idx,
                                            input logic [31:0] arg,
                                            input logic [6:0] crc);
    logic [7:0] b;
    case (k)
      3'd0:    b = 8'hFF;
      3'd1:    b = {2'b01, idx};
      3'd2:    b = arg[31:24];
      3'd3:    b = arg[23:16];
      3'd4:    b = arg[15:8];
      3'd5:    b = arg[7:0];
      default: b = {crc, 1'b1};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/spi_byte_xchg.sv
module spi_byte_xchg #(
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [7:0]        tx_byte,
  input  logic [HALF_W-1:0] half_cnt,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [7:0]        rx_byte,
  output logic              byte_done
);

  logic              active;
  logic              phase_hi;
  logic [2:0]        bit_i;
  logic [HALF_W-1:0] div;
  logic [7:0]        sh_tx;
  logic [7:0]        sh_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      phase_hi  <= 1'b0;
      bit_i     <= 3'd0;
      div       <= '0;
      sh_tx     <= 8'hFF;
      sh_rx     <= 8'h00;
      sclk      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (go) begin
        active   <= 1'b1;
        phase_hi <= 1'b0;
        bit_i    <= 3'd0;
        div      <= '0;
        sh_tx    <= tx_byte;
        sclk     <= 1'b0;
      end else if (active) begin
        if (div == half_cnt) begin
          div <= '0;
          if (!phase_hi) begin
            sclk     <= 1'b1;
            sh_rx    <= {sh_rx[6:0], miso};
            phase_hi <= 1'b1;
          end else begin
            sclk     <= 1'b0;
            phase_hi <= 1'b0;
            if (bit_i == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
              sh_tx     <= 8'hFF;
            end else begin
              bit_i <= bit_i + 3'd1;
              sh_tx <= {sh_tx[6:0], 1'b1};
            end
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  assign mosi    = sh_tx[7];
  assign rx_byte = sh_rx;

endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import sdcmd_pkg::*;
#(
  parameter int RUN_HALF   = 2,
  parameter int INIT_HALF  = 8,
  parameter int POLL_MAX   = 8,
  parameter int INIT_BYTES = 18,
  parameter int HALF_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wake_mode,
  input  logic [5:0]        cmd_idx,
  input  logic [31:0]       cmd_arg,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  output logic              go,
  output logic [7:0]        tx_byte,
  output logic [HALF_W-1:0] half_cnt,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic [7:0]        r1,
  output logic              timeout,
  output logic              wake_run
);

  localparam int MAX_CNT = (INIT_BYTES > POLL_MAX) ?
                           ((INIT_BYTES > FRAME_BYTES) ? INIT_BYTES : FRAME_BYTES) :
                           ((POLL_MAX > FRAME_BYTES) ? POLL_MAX : FRAME_BYTES);
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [5:0]        idx_q;
  logic [31:0]       arg_q;
  logic [6:0]        crc_q;
  logic              hit;
  logic              last_poll;
  logic [CNT_W-1:0]  cnt_nx;

  assign cnt_nx    = cnt + 1'b1;
  assign hit       = (cnt != '0) && !rx_byte[7];
  assign last_poll = (cnt == CNT_W'(POLL_MAX - 1));
  assign wake_run  = (state == SQ_WAKE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      go       <= 1'b0;
      tx_byte  <= 8'hFF;
      half_cnt <= HALF_W'(RUN_HALF - 1);
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      r1       <= 8'h00;
      timeout  <= 1'b0;
      idx_q    <= 6'd0;
      arg_q    <= 32'd0;
      crc_q    <= 7'd0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            busy    <= 1'b1;
            go      <= 1'b1;
            tx_byte <= 8'hFF;
            cnt     <= '0;
            if (wake_mode) begin
              state    <= SQ_WAKE;
              half_cnt <= HALF_W'(INIT_HALF - 1);
            end else begin
              state    <= SQ_SEND;
              half_cnt <= HALF_W'(RUN_HALF - 1);
              cs_n     <= 1'b0;
              idx_q    <= cmd_idx;
              arg_q    <= cmd_arg;
              crc_q    <= crc7_calc({2'b01, cmd_idx, cmd_arg});
            end
          end
        end
        SQ_WAKE: begin
          if (byte_done) begin
            if (cnt == CNT_W'(INIT_BYTES - 1)) begin
              state   <= SQ_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              r1      <= 8'h00;
              timeout <= 1'b0;
            end else begin
              cnt     <= cnt_nx;
              go      <= 1'b1;
              tx_byte <= 8'hFF;
            end
          end
        end
        SQ_SEND: begin
          if (byte_done) begin
            go <= 1'b1;
            if (cnt == CNT_W'(FRAME_BYTES - 1)) begin
              state   <= SQ_POLL;
              cnt     <= '0;
              tx_byte <= 8'hFF;
            end else begin
              cnt     <= cnt_nx;
              tx_byte <= frame_byte(3'(cnt_nx), idx_q, arg_q, crc_q);
            end
          end
        end
        SQ_POLL: begin
          if (byte_done) begin
            if (hit || last_poll) begin
              state   <= SQ_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              cs_n    <= 1'b1;
              r1      <= rx_byte;
              timeout <= !hit;
            end else begin
              cnt     <= cnt_nx;
              go      <= 1'b1;
              tx_byte <= 8'hFF;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/r1_classify.sv
module r1_classify (
  input  logic [7:0] r1,
  output logic       no_card,
  output logic       crc_err,
  output logic       gen_err,
  output logic       card_idle
);

  always_comb begin
    no_card   = (r1 == 8'hFF);
    crc_err   = !no_card && r1[3];
    gen_err   = !no_card && !r1[3] && (r1[7:1] != 7'd0);
    card_idle = !no_card && r1[0];
  end

endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int RUN_HALF   = 2,
  parameter int INIT_HALF  = 8,
  parameter int POLL_MAX   = 8,
  parameter int INIT_BYTES = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wake_mode,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic [7:0]  r1,
  output logic        timeout,
  output logic        no_card,
  output logic        crc_err,
  output logic        gen_err,
  output logic        card_idle,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n
);

  localparam int MAX_HALF = (INIT_HALF > RUN_HALF) ? INIT_HALF : RUN_HALF;
  localparam int HALF_W   = (MAX_HALF < 2) ? 1 : $clog2(MAX_HALF);

  logic              go;
  logic [7:0]        tx_byte;
  logic [HALF_W-1:0] half_cnt;
  logic [7:0]        rx_byte;
  logic              byte_done;
  logic              wake_run;

  cmd_seq #(
    .RUN_HALF  (RUN_HALF),
    .INIT_HALF (INIT_HALF),
    .POLL_MAX  (POLL_MAX),
    .INIT_BYTES(INIT_BYTES),
    .HALF_W    (HALF_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wake_mode(wake_mode),
    .cmd_idx  (cmd_idx),
    .cmd_arg  (cmd_arg),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .go       (go),
    .tx_byte  (tx_byte),
    .half_cnt (half_cnt),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done),
    .r1       (r1),
    .timeout  (timeout),
    .wake_run (wake_run)
  );

  spi_byte_xchg #(.HALF_W(HALF_W)) u_xchg (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .tx_byte  (tx_byte),
    .half_cnt (half_cnt),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .rx_byte  (rx_byte),
    .byte_done(byte_done)
  );

  r1_classify u_cls (
    .r1       (r1),
    .no_card  (no_card),
    .crc_err  (crc_err),
    .gen_err  (gen_err),
    .card_idle(card_idle)
  );

endmodule

// File: rtl/sd_cmd_issuer_chk.sv
module sd_cmd_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       sclk,
  input logic [7:0] r1,
  input logic       timeout,
  input logic       no_card,
  input logic       crc_err,
  input logic       gen_err,
  input logic       wake_run,
  input logic       byte_done
);

  AST_WAKE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wake_run |-> cs_n); // R7
  AST_DONE_CS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy)); // R6
  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !byte_done) |-> !sclk); // R1
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({no_card, crc_err, gen_err})); // R5
  AST_TIMEOUT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> r1[7]); // R4
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(r1) && $stable(timeout))); // R8

endmodule

bind sd_cmd_issuer sd_cmd_issuer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .r1       (r1),
  .timeout  (timeout),
  .no_card  (no_card),
  .crc_err  (crc_err),
  .gen_err  (gen_err),
  .wake_run (wake_run),
  .byte_done(byte_done)
);

// File: tb/sd_cmd_issuer_bench.sv
`timescale 1ns/1ps
module sd_cmd_issuer_bench;

  localparam int RUN_HALF  = 2;
  localparam int INIT_HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wake_mode = 1'b0;
  logic [5:0]  cmd_idx = 6'd0;
  logic [31:0] cmd_arg = 32'd0;
  logic        miso;
  logic        busy, done, timeout, no_card, crc_err, gen_err, card_idle;
  logic        sclk, mosi, cs_n;
  logic [7:0]  r1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] pkt  [0:15];
  logic [7:0] resp [0:7];
  int  rise_cnt = 0;
  int  wake_rises = 0;
  logic tb_clr = 1'b0;

  always #2.5 clk = ~clk;

  sd_cmd_issuer #(.RUN_HALF(RUN_HALF), .INIT_HALF(INIT_HALF)) u_sd_cmd_issuer (
    .clk(clk), .rst_n(rst_n), .start(start), .wake_mode(wake_mode),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .miso(miso), .busy(busy),
    .done(done), .r1(r1), .timeout(timeout), .no_card(no_card),
    .crc_err(crc_err), .gen_err(gen_err), .card_idle(card_idle),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  // card model: capture MOSI on rising SCLK, present next MISO bit afterwards
  always @(posedge sclk or posedge tb_clr) begin
    if (tb_clr) begin
      rise_cnt   <= 0;
      wake_rises <= 0;
    end else if (!cs_n) begin
      if (rise_cnt < 128) pkt[rise_cnt / 8][7 - (rise_cnt % 8)] <= mosi;
      rise_cnt <= rise_cnt + 1;
    end else begin
      wake_rises <= wake_rises + 1;
    end
  end

  always_comb begin
    int bi;
    bi = rise_cnt / 8;
    if (!cs_n && bi >= 7 && bi < 15) miso = resp[bi - 7][7 - (rise_cnt % 8)];
    else miso = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench CRC7: byte-wise, bit by bit
  function automatic logic [6:0] ref_crc7(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2, input logic [7:0] b3,
                                          input logic [7:0] b4);
    logic [7:0] bytes [0:4];
    logic [6:0] c;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3; bytes[4] = b4;
    c = 7'd0;
    for (int n = 0; n < 5; n++) begin
      for (int k = 7; k >= 0; k--) begin
        if (c[6] != bytes[n][k]) c = (c << 1) ^ 7'h09;
        else c = c << 1;
      end
    end
    return c;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit poke);
    logic [7:0] b1, exp_r1, exp_crcb;
    bit exp_to, nc;
    int nbytes, n;
    @(negedge clk);
    tb_clr = 1'b1; #1 tb_clr = 1'b0;
    exp_to = 1'b1; nbytes = 8; exp_r1 = resp[7];
    for (int i = 1; i < 8; i++) begin
      if (!resp[i][7]) begin exp_r1 = resp[i]; exp_to = 1'b0; nbytes = i + 1; break; end
    end
    b1 = {2'b01, idx};
    exp_crcb = {ref_crc7(b1, arg[31:24], arg[23:16], arg[15:8], arg[7:0]), 1'b1};
    @(negedge clk);
    start = 1'b1; wake_mode = 1'b0; cmd_idx = idx; cmd_arg = arg;
    @(negedge clk);
    start = 1'b0; cmd_idx = ~idx; cmd_arg = ~arg;
    chk(cs_n == 1'b0, "R6 cs_n low after start", cs_n, 0);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; cmd_idx = idx ^ 6'h15;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R8 done pulse", done, 1);
    chk(pkt[0] == 8'hFF, "R1 filler byte", pkt[0], 8'hFF);
    chk(pkt[1] == b1, "R1 index byte", pkt[1], b1);
    chk({pkt[2], pkt[3], pkt[4], pkt[5]} == arg, "R1 argument bytes",
        {pkt[2], pkt[3], pkt[4], pkt[5]}, arg);
    chk(pkt[6] == exp_crcb, "R2 crc byte", pkt[6], exp_crcb);
    chk(rise_cnt == (7 + nbytes) * 8, "R3 sclk edge count", rise_cnt, (7 + nbytes) * 8);
    chk(r1 == exp_r1, "R3 r1 value", r1, exp_r1);
    chk(timeout == exp_to, "R4 timeout flag", timeout, exp_to);
    nc = (exp_r1 == 8'hFF);
    chk(no_card == nc, "R5 no_card", no_card, nc);
    chk(crc_err == (!nc && exp_r1[3]), "R5 crc_err", crc_err, !nc && exp_r1[3]);
    chk(gen_err == (!nc && !exp_r1[3] && exp_r1[7:1] != 0), "R5 gen_err", gen_err,
        !nc && !exp_r1[3] && exp_r1[7:1] != 0);
    chk(card_idle == (!nc && exp_r1[0]), "R5 card_idle", card_idle, !nc && exp_r1[0]);
    chk(cs_n == 1'b1 && busy == 1'b0, "R6 cs_n released at done", {cs_n, busy}, 2'b10);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b0 && cs_n == 1'b1, "R8 start while busy ignored", {busy, cs_n}, 2'b01);
    end
  endtask

  task automatic set_resp(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] rest, input logic [7:0] last);
    resp[0] = a0; resp[1] = a1;
    for (int i = 2; i < 7; i++) resp[i] = rest;
    resp[7] = last;
  endtask

  initial begin
    int bc;
    void'($urandom(32'd20240611));
    set_resp(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b1, "R9 reset pins", {cs_n, sclk, mosi}, 3'b101);
    chk(busy == 1'b0 && done == 1'b0, "R9 reset handshake", {busy, done}, 0);
    chk(r1 == 8'h00 && timeout == 1'b0, "R9 reset result", {r1, timeout}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 wake preamble
    tb_clr = 1'b1; #1 tb_clr = 1'b0;
    @(negedge clk);
    start = 1'b1; wake_mode = 1'b1;
    @(negedge clk);
    start = 1'b0; wake_mode = 1'b0;
    bc = 1;
    while (!done && bc < 10000) begin @(negedge clk); bc++; end
    chk(wake_rises == 144, "R7 wake sclk edges", wake_rises, 144);
    chk(rise_cnt == 0, "R7 no edges with cs low", rise_cnt, 0);
    chk(bc >= 144 * 2 * INIT_HALF, "R7 slow sclk", bc, 144 * 2 * INIT_HALF);
    chk(r1 == 8'h00 && timeout == 1'b0, "R7 wake result", {r1, timeout}, 0);

    // directed corner cases
    set_resp(8'hFF, 8'h01, 8'hFF, 8'hFF); run_cmd(6'd0, 32'd0, 1'b0);
    chk(pkt[6] == 8'h95, "R2 CMD0 crc constant", pkt[6], 8'h95);
    set_resp(8'hFF, 8'h01, 8'hFF, 8'hFF); run_cmd(6'd8, 32'h000001AA, 1'b0);
    chk(pkt[6] == 8'h87, "R2 CMD8 crc constant", pkt[6], 8'h87);
    set_resp(8'h00, 8'hFF, 8'hFF, 8'hFF); run_cmd(6'd55, 32'h0, 1'b0);  // R3 first byte discarded -> R4
    set_resp(8'hFF, 8'hFF, 8'hFF, 8'h00); run_cmd(6'd17, 32'h12345678, 1'b0); // R3 last byte
    set_resp(8'hFF, 8'hFF, 8'hFF, 8'h80); run_cmd(6'd24, 32'hDEADBEEF, 1'b0); // R4 R5 gen
    set_resp(8'hFF, 8'h09, 8'hFF, 8'hFF); run_cmd(6'd41, 32'h40000000, 1'b0); // R5 crc+idle
    set_resp(8'hFF, 8'h04, 8'hFF, 8'hFF); run_cmd(6'd63, 32'hFFFFFFFF, 1'b1); // R5 R8
    set_resp(8'hFF, 8'hFF, 8'hFF, 8'hFF); run_cmd(6'd1, 32'h00FF00FF, 1'b0);  // R5 no card

    // constrained random
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 8; i++) begin
        case ($urandom % 4)
          0: resp[i] = 8'hFF;
          1: resp[i] = {1'b1, 7'($urandom)};
          2: resp[i] = {1'b0, 7'($urandom)};
          default: resp[i] = 8'hFF;
        endcase
      end
      run_cmd(6'($urandom), $urandom, (t % 10) == 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule